// File: doc/BRIEF.md
# Windowed Threshold Alert Comparator

This block watches the stream of 12-bit straight-binary conversion results coming out of a two-channel sampling front end and decides, for each channel, whether the signal has left its allowed window. Every channel has its own upper limit, lower limit, hysteresis margin and consecutive-event requirement. A short excursion is rejected until enough out-of-window results arrive in a row. A signal hovering at a limit is kept inside its "outside" condition by the hysteresis margin, so it does not chatter in and out.

When a channel qualifies often enough, a sticky high or low flag is set for it. The host clears flags by writing a clear strobe with a bit mask. A single active-low alert output, suitable for an open-drain pad, is asserted while any flag whose enable bit is set is high. Only this comparator logic drives the alert output. The conversion itself and the host serial interface live outside this block.

Top module: `window_alert_cmp`

## Requirements
- R1: After reset, `alert_n` is 1 and every bit of `alert_flags` is 0.
- R2: A result qualifies as high when the code is strictly greater than its channel's high limit. A code equal to the limit does not qualify.
- R3: A result qualifies as low when the code is strictly less than its channel's low limit. A code equal to the limit does not qualify.
- R4: Once a channel's high condition is active, it stays active while the code is at least (high limit minus hysteresis). The lower bound saturates at 0. It clears on the first code below that bound.
- R5: Once a channel's low condition is active, it stays active while the code is at most (low limit plus hysteresis). The upper bound saturates at 4095. It clears on the first code above that bound.
- R6: With a 4-bit event setting N for a channel, a flag is set on the (N+1)-th consecutive qualifying result of that channel. The event counter saturates at N, so every further consecutive qualifying result sets the flag again. With N=0 a single result sets it.
- R7: An in-window result, meaning neither high nor low qualifying, resets that channel's event counter to 0.
- R8: A result affects only the channel named by `res_ch`. The state of other channels is unchanged.
- R9: Flags are sticky. `alert_flags[2c]` is the high flag of channel c and `alert_flags[2c+1]` is its low flag. A `clr_valid` cycle clears exactly the bits set in `clr_mask`. A flag being set in the same cycle as its clear stays set.
- R10: `alert_n` is registered and equals NOT(OR of `alert_flags & cfg_alert_en`), updated on the same edge as the flags. The enable bits never change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | 1 | Channel of the result |
| res_code | input | 12 | Result code, straight binary |
| cfg_hi_thr | input | 24 | High limits, channel c at bits [12c+11:12c] |
| cfg_lo_thr | input | 24 | Low limits, same packing |
| cfg_hyst | input | 24 | Hysteresis margins, same packing |
| cfg_evt_cnt | input | 8 | Event settings, channel c at bits [4c+3:4c] |
| cfg_alert_en | input | 4 | Per-flag alert enable, same bit order as the flags |
| clr_valid | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Flags to clear |
| alert_n | output | 1 | Active-low alert |
| alert_flags | output | 4 | Sticky per-channel high/low flags |

## Verification
The limits are probed with codes exactly at and one step past each limit, to separate a strict compare from an inclusive one. Hysteresis is exercised by stepping back inside the limit but not past the release bound, then past it. This shows whether the held condition persists and where it lets go. Interleaved results from both channels, with a count of two on one channel, show whether counters are per channel and reset on in-window results. Limits placed near 0 and 4095 with a wide margin expose a release bound that wraps instead of saturating. Simultaneous set and clear, and enable-mask changes, separate flag state from the pin.

// File: rtl/wac_pkg.sv
package wac_pkg;
  // Number of flags kept for each channel and their slot within a channel.
  localparam int FLAGS_PER_CH = 2;
  localparam int SLOT_HI      = 0;
  localparam int SLOT_LO      = 1;

  // Qualification result of one conversion against one channel's window.
  typedef struct packed {
    logic hi;
    logic lo;
  } wac_qual_t;
endpackage

// File: rtl/wac_thresh_eval.sv
module wac_thresh_eval
  import wac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] code,
  input  logic [DATA_W-1:0] hi_thr,
  input  logic [DATA_W-1:0] lo_thr,
  input  logic [DATA_W-1:0] hyst,
  input  logic              hi_held,
  input  logic              lo_held,
  output wac_qual_t         qual
);
  localparam logic [DATA_W-1:0] CODE_MAX = '1;

  logic [DATA_W-1:0] hi_release;
  logic [DATA_W:0]   lo_sum;
  logic [DATA_W-1:0] lo_release;

  // Release bounds saturate at the ends of the code range.
  always_comb begin
    hi_release = (hi_thr >= hyst) ? (hi_thr - hyst) : '0;
    lo_sum     = {1'b0, lo_thr} + {1'b0, hyst};
    lo_release = lo_sum[DATA_W] ? CODE_MAX : lo_sum[DATA_W-1:0];
  end

  always_comb begin
    qual.hi = (code > hi_thr) || (hi_held && (code >= hi_release));
    qual.lo = (code < lo_thr) || (lo_held && (code <= lo_release));
  end
endmodule

// File: rtl/wac_chan_track.sv
module wac_chan_track
  import wac_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  wac_qual_t        qual,
  input  logic [CNT_W-1:0] evt_cfg,
  input  logic             clr_hi,
  input  logic             clr_lo,
  output logic             hi_held,
  output logic             lo_held,
  output logic             flag_hi,
  output logic             flag_lo,
  output logic             flag_hi_nxt,
  output logic             flag_lo_nxt
);
  logic [CNT_W-1:0] cnt;
  logic             in_window;
  logic             reached;
  logic             raise_hi;
  logic             raise_lo;

  always_comb begin
    in_window   = !qual.hi && !qual.lo;
    reached     = (cnt >= evt_cfg);
    raise_hi    = hit && qual.hi && reached;
    raise_lo    = hit && qual.lo && reached;
    flag_hi_nxt = raise_hi || (flag_hi && !clr_hi);
    flag_lo_nxt = raise_lo || (flag_lo && !clr_lo);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      hi_held <= 1'b0;
      lo_held <= 1'b0;
    end else if (hit) begin
      hi_held <= qual.hi;
      lo_held <= qual.lo;
      if (in_window) begin
        cnt <= '0;
      end else if (!reached) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else begin
      flag_hi <= flag_hi_nxt;
      flag_lo <= flag_lo_nxt;
    end
  end

  // R7: an in-window result empties the counter
  a_r7_window_resets_count: assert property (@(posedge clk) disable iff (rst)
    (hit && !qual.hi && !qual.lo) |=> (cnt == '0));

  // R8: counter and held state move only on this channel's results
  a_r8_idle_channel_stable: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(cnt) && $stable(hi_held) && $stable(lo_held)));

  // R9: a set flag survives any cycle without its clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_hi && !clr_hi) |=> flag_hi);

  // R6: a flag can only rise on a qualifying result of this channel
  a_r6_rise_needs_result: assert property (@(posedge clk) disable iff (rst)
    (!flag_lo && !(hit && qual.lo)) |=> !flag_lo);
endmodule

// File: rtl/wac_alert_drive.sv
module wac_alert_drive #(
  parameter int N_FLAGS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLAGS-1:0] flags_nxt,
  input  logic [N_FLAGS-1:0] enable,
  output logic               alert_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alert_n <= 1'b1;
    end else begin
      alert_n <= ~(|(flags_nxt & enable));
    end
  end
endmodule

// File: rtl/window_alert_cmp.sv
module window_alert_cmp
  import wac_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int N_FLAGS = FLAGS_PER_CH * NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     res_valid,
  input  logic [CH_W-1:0]          res_ch,
  input  logic [DATA_W-1:0]        res_code,
  input  logic [NUM_CH*DATA_W-1:0] cfg_hi_thr,
  input  logic [NUM_CH*DATA_W-1:0] cfg_lo_thr,
  input  logic [NUM_CH*DATA_W-1:0] cfg_hyst,
  input  logic [NUM_CH*CNT_W-1:0]  cfg_evt_cnt,
  input  logic [N_FLAGS-1:0]       cfg_alert_en,
  input  logic                     clr_valid,
  input  logic [N_FLAGS-1:0]       clr_mask,
  output logic                     alert_n,
  output logic [N_FLAGS-1:0]       alert_flags
);
  logic [N_FLAGS-1:0] flags_nxt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wac_qual_t qual;
    logic      hit;
    logic      hi_held;
    logic      lo_held;

    assign hit = res_valid && (res_ch == CH_W'(c));

    wac_thresh_eval #(.DATA_W(DATA_W)) u_eval (
      .code    (res_code),
      .hi_thr  (cfg_hi_thr[c*DATA_W +: DATA_W]),
      .lo_thr  (cfg_lo_thr[c*DATA_W +: DATA_W]),
      .hyst    (cfg_hyst[c*DATA_W +: DATA_W]),
      .hi_held (hi_held),
      .lo_held (lo_held),
      .qual    (qual)
    );

    wac_chan_track #(.CNT_W(CNT_W)) u_track (
      .clk         (clk),
      .rst         (rst),
      .hit         (hit),
      .qual        (qual),
      .evt_cfg     (cfg_evt_cnt[c*CNT_W +: CNT_W]),
      .clr_hi      (clr_valid && clr_mask[FLAGS_PER_CH*c + SLOT_HI]),
      .clr_lo      (clr_valid && clr_mask[FLAGS_PER_CH*c + SLOT_LO]),
      .hi_held     (hi_held),
      .lo_held     (lo_held),
      .flag_hi     (alert_flags[FLAGS_PER_CH*c + SLOT_HI]),
      .flag_lo     (alert_flags[FLAGS_PER_CH*c + SLOT_LO]),
      .flag_hi_nxt (flags_nxt[FLAGS_PER_CH*c + SLOT_HI]),
      .flag_lo_nxt (flags_nxt[FLAGS_PER_CH*c + SLOT_LO])
    );
  end

  wac_alert_drive #(.N_FLAGS(N_FLAGS)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .flags_nxt (flags_nxt),
    .enable    (cfg_alert_en),
    .alert_n   (alert_n)
  );

  // R10: the pin is only low while some flag is held
  a_r10_pin_needs_flag: assert property (@(posedge clk) disable iff (rst)
    !alert_n |-> (|alert_flags));

  // R9: with no clear pending and no result, the flags do not move
  a_r9_flags_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !clr_valid) |=> $stable(alert_flags));

  // R1: reset leaves the pin released and the flags empty
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (alert_n && (alert_flags == '0)));
endmodule

// File: tb/window_alert_cmp_bench.sv
module window_alert_cmp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [0:0]  res_ch = '0;
  logic [11:0] res_code = '0;
  logic [23:0] cfg_hi_thr = {12'd2000, 12'd3000};
  logic [23:0] cfg_lo_thr = {12'd500, 12'd1000};
  logic [23:0] cfg_hyst   = {12'd50, 12'd100};
  logic [7:0]  cfg_evt_cnt = {4'd2, 4'd0};
  logic [3:0]  cfg_alert_en = 4'hF;
  logic        clr_valid = 1'b0;
  logic [3:0]  clr_mask = '0;
  logic        alert_n;
  logic [3:0]  alert_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  window_alert_cmp u_window_alert_cmp (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_ch(res_ch),
    .res_code(res_code), .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
    .cfg_hyst(cfg_hyst), .cfg_evt_cnt(cfg_evt_cnt), .cfg_alert_en(cfg_alert_en),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .alert_n(alert_n),
    .alert_flags(alert_flags)
  );

  typedef struct packed {
    logic        clr;
    logic        ch;
    logic [11:0] code;
    logic [3:0]  mask;
    logic [3:0]  ef;
    logic        en;
    logic [3:0]  req;
  } vec_t;

  // ch0: hi 3000 lo 1000 hyst 100 N 0; ch1: hi 2000 lo 500 hyst 50 N 2
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    {1'b0, 1'b0, 12'd3000, 4'h0, 4'h0, 1'b1, 4'd2},  // R2 equal is not high
    {1'b0, 1'b0, 12'd3001, 4'h0, 4'h1, 1'b0, 4'd2},  // R2 one above
    {1'b1, 1'b0, 12'd0,    4'h1, 4'h0, 1'b1, 4'd9},  // R9 clear
    {1'b0, 1'b0, 12'd2950, 4'h0, 4'h1, 1'b0, 4'd4},  // R4 held by margin
    {1'b1, 1'b0, 12'd0,    4'h1, 4'h0, 1'b1, 4'd9},
    {1'b0, 1'b0, 12'd2899, 4'h0, 4'h0, 1'b1, 4'd4},  // R4 below release
    {1'b0, 1'b0, 12'd2950, 4'h0, 4'h0, 1'b1, 4'd4},  // R4 no longer held
    {1'b0, 1'b0, 12'd1000, 4'h0, 4'h0, 1'b1, 4'd3},  // R3 equal is not low
    {1'b0, 1'b0, 12'd999,  4'h0, 4'h2, 1'b0, 4'd3},  // R3 one below
    {1'b1, 1'b0, 12'd0,    4'h2, 4'h0, 1'b1, 4'd9},
    {1'b0, 1'b0, 12'd1100, 4'h0, 4'h2, 1'b0, 4'd5},  // R5 held at bound
    {1'b1, 1'b0, 12'd0,    4'h2, 4'h0, 1'b1, 4'd9},
    {1'b0, 1'b0, 12'd1101, 4'h0, 4'h0, 1'b1, 4'd5},  // R5 above release
    {1'b0, 1'b0, 12'd1050, 4'h0, 4'h0, 1'b1, 4'd5},  // R5 no longer held
    {1'b0, 1'b1, 12'd2001, 4'h0, 4'h0, 1'b1, 4'd6},  // R6 first of three
    {1'b0, 1'b1, 12'd2001, 4'h0, 4'h0, 1'b1, 4'd6},
    {1'b0, 1'b1, 12'd2001, 4'h0, 4'h4, 1'b0, 4'd6},  // R6 third sets flag
    {1'b1, 1'b0, 12'd0,    4'h4, 4'h0, 1'b1, 4'd9},
    {1'b0, 1'b1, 12'd2100, 4'h0, 4'h4, 1'b0, 4'd6},  // R6 saturated count
    {1'b1, 1'b0, 12'd0,    4'h4, 4'h0, 1'b1, 4'd9},
    {1'b0, 1'b1, 12'd1000, 4'h0, 4'h0, 1'b1, 4'd7},  // R7 in window
    {1'b0, 1'b1, 12'd2001, 4'h0, 4'h0, 1'b1, 4'd7},  // R7 count restarted
    {1'b0, 1'b0, 12'd3500, 4'h0, 4'h1, 1'b0, 4'd8},  // R8 other channel
    {1'b0, 1'b1, 12'd2001, 4'h0, 4'h1, 1'b0, 4'd8},  // R8 ch1 count kept
    {1'b0, 1'b1, 12'd1980, 4'h0, 4'h5, 1'b0, 4'd4},  // R4 held counts
    {1'b1, 1'b0, 12'd0,    4'h5, 4'h0, 1'b1, 4'd9},
    {1'b0, 1'b1, 12'd1949, 4'h0, 4'h0, 1'b1, 4'd7},
    {1'b0, 1'b1, 12'd1980, 4'h0, 4'h0, 1'b1, 4'd7},
    {1'b0, 1'b1, 12'd499,  4'h0, 4'h0, 1'b1, 4'd6},
    {1'b0, 1'b1, 12'd499,  4'h0, 4'h0, 1'b1, 4'd6},
    {1'b0, 1'b1, 12'd499,  4'h0, 4'h8, 1'b0, 4'd6}   // R6 low flag
  };

  task automatic check(input logic [3:0] ef, input logic en, input int req);
    checks++;
    if (alert_flags !== ef) begin
      errors++;
      $display("FAIL R%0d flags actual %h expected %h", req, alert_flags, ef);
    end
    checks++;
    if (alert_n !== en) begin
      errors++;
      $display("FAIL R%0d alert_n actual %b expected %b", req, alert_n, en);
    end
  endtask

  task automatic step(input logic do_res, input logic ch, input logic [11:0] code,
                      input logic do_clr, input logic [3:0] mask);
    @(negedge clk);
    res_valid = do_res; res_ch = ch; res_code = code;
    clr_valid = do_clr; clr_mask = mask;
    @(negedge clk);
    res_valid = 1'b0; clr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check(4'h0, 1'b1, 1);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].clr) step(1'b0, 1'b0, 12'd0, 1'b1, VEC[i].mask);
      else            step(1'b1, VEC[i].ch, VEC[i].code, 1'b0, 4'h0);
      check(VEC[i].ef, VEC[i].en, int'(VEC[i].req));
    end

    // R10: masking the only set flag releases the pin, flags kept
    @(negedge clk); cfg_alert_en = 4'h7;
    @(negedge clk); check(4'h8, 1'b1, 10);
    @(negedge clk); cfg_alert_en = 4'hF;
    @(negedge clk); check(4'h8, 1'b0, 10);

    // R9: set wins over a clear in the same cycle
    step(1'b1, 1'b1, 12'd499, 1'b1, 4'h8);
    check(4'h8, 1'b0, 9);
    // R9: clear touches only masked bits
    step(1'b0, 1'b0, 12'd0, 1'b1, 4'h7);
    check(4'h8, 1'b0, 9);

    // R1: mid-run reset
    do_reset();
    check(4'h0, 1'b1, 1);

    // R4: release bound saturates at 0
    cfg_hi_thr[11:0] = 12'd50; cfg_lo_thr[11:0] = 12'd0; cfg_hyst[11:0] = 12'd100;
    step(1'b1, 1'b0, 12'd51, 1'b0, 4'h0);
    check(4'h1, 1'b0, 4);
    step(1'b0, 1'b0, 12'd0, 1'b1, 4'h1);
    step(1'b1, 1'b0, 12'd0, 1'b0, 4'h0);
    check(4'h1, 1'b0, 4);

    // R5: release bound saturates at 4095
    do_reset();
    cfg_hi_thr[11:0] = 12'd4095; cfg_lo_thr[11:0] = 12'd4050;
    step(1'b1, 1'b0, 12'd4049, 1'b0, 4'h0);
    check(4'h2, 1'b0, 5);
    step(1'b0, 1'b0, 12'd0, 1'b1, 4'h2);
    step(1'b1, 1'b0, 12'd4095, 1'b0, 4'h0);
    check(4'h2, 1'b0, 5);  // R2 also: 4095 not above limit 4095

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule